// File: doc/BRIEF.md
# Two-Byte Register-File Processor

A small multi-cycle processor core with sixteen 8-bit general registers, a program counter and a 16-bit instruction register. Every instruction is one 16-bit word. The upper byte holds a 4-bit opcode in bits [15:12] and a destination/condition register index Rn in bits [11:8]. The lower byte is one of three things:
- a direct data address,
- an 8-bit immediate,
- a signed branch displacement.

For register-pair operations, Rm sits in bits [7:4].

Each instruction passes through five one-cycle phases: fetch, decode, operand read, execute and commit. Both memories are synchronous and return read data in the cycle after the address is presented.

The core reads instructions from a separate 16-bit-wide program memory, which is indexed by PC in whole instructions. It loads and stores bytes in a 256-entry data memory. Opcodes 7 through 15 stop the core, which then waits for reset.

Top module: `rfc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core clears PC, the instruction register and all sixteen registers, and deasserts `halted`. After reset, `imemAddr` reads 0, `dmemWe` reads 0, and a register stored before any write yields 0x00.
- R2: Every executed instruction takes exactly five clock cycles. Two stores that are k instructions apart therefore pulse `dmemWe` exactly 5*k cycles apart.
- R3: Opcode 0x0 loads Rn from data address imm (bits [7:0]). Opcode 0x1 writes Rn to data address imm.
- R4: Opcode 0x2 writes Rm (bits [7:4]) to the data address held in Rn.
- R5: Opcode 0x3 copies the low byte (bits [7:0]) into Rn.
- R6: Opcode 0x4 sets Rn = Rn + Rm, and opcode 0x5 sets Rn = Rn - Rm, both modulo 256. This holds when Rn and Rm name the same register.
- R7: Opcode 0x6, when Rn is zero, sets PC to the branch's own address plus the sign-extended low byte. Otherwise PC advances by one.
- R8: Opcodes 0x7 to 0xF assert `halted` until reset. While halted, `imemAddr` keeps the address of the halting instruction and `dmemWe` stays low.
- R9: The countdown program that adds 10, 9, ..., 1 into R0 ends with R0 = 55 and R1 = 0. It uses R2 = 1 as the decrement and R3 = 0 for an always-taken branch.
- R10: `dmemWe` pulses for one cycle per store instruction (opcodes 0x1 and 0x2) and never for any other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 8 | Program memory word address (PC) |
| imemData | input | 16 | Program word, valid one cycle after address |
| dmemAddr | output | 8 | Data memory byte address |
| dmemWe | output | 1 | Data memory write strobe |
| dmemWdata | output | 8 | Data memory write byte |
| dmemRdata | input | 8 | Data memory read byte, valid one cycle after address |
| halted | output | 1 | Core stopped by an undefined opcode |

## Verification
Two functions can collide in one cycle: both register read ports can address the same entry, and the commit phase can write the register file and update PC on the same edge. The bench provokes the read-port collision with an add of R15 to itself, expecting 0xFE from 0xFF. It also uses an indirect store whose address and data come from two different registers in the same operand read. For the commit collision, it places a taken branch directly after the register write that zeroed its condition register. A wrong jump then shows up as a skipped or extra store at the data port. The scoreboard checks each store's address, data and cycle spacing.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam logic [3:0] OP_LDD = 4'h0;
  localparam logic [3:0] OP_STD = 4'h1;
  localparam logic [3:0] OP_STI = 4'h2;
  localparam logic [3:0] OP_LDI = 4'h3;
  localparam logic [3:0] OP_ADD = 4'h4;
  localparam logic [3:0] OP_SUB = 4'h5;
  localparam logic [3:0] OP_BRZ = 4'h6;

  typedef struct packed {
    logic irLoad;
    logic opLatch;
    logic resLoad;
    logic commit;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_OPER, ST_EXEC, ST_STORE, ST_HALTED
  } phase_t;
endpackage

// File: rtl/rfc_control.sv
module rfc_control
  import rfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  fetchedOp,
  output ctrlStrobe_t strb,
  output logic        halted
);
  phase_t st;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_FETCH;
    else begin
      case (st)
        ST_FETCH:  st <= ST_DECODE;
        ST_DECODE: st <= (fetchedOp > OP_BRZ) ? ST_HALTED : ST_OPER;
        ST_OPER:   st <= ST_EXEC;
        ST_EXEC:   st <= ST_STORE;
        ST_STORE:  st <= ST_FETCH;
        default:   st <= ST_HALTED;
      endcase
    end
  end

  always_comb begin
    strb.irLoad  = (st == ST_DECODE);
    strb.opLatch = (st == ST_OPER);
    strb.resLoad = (st == ST_EXEC);
    strb.commit  = (st == ST_STORE);
    halted       = (st == ST_HALTED);
  end

  // R2: decode leads to operand read or halt, never elsewhere
  p_decode_next_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE) |=> (st == ST_OPER || st == ST_HALTED));

  // R8: halt holds until reset
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
endmodule

// File: rtl/rfc_datapath.sv
module rfc_datapath
  import rfc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PCW  = 8,
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrlStrobe_t     strb,
  input  logic [15:0]     imemData,
  input  logic [DW-1:0]   dmemRdata,
  output logic [PCW-1:0]  pc,
  output logic [DW-1:0]   dmemAddr,
  output logic            dmemWe,
  output logic [DW-1:0]   dmemWdata
);
  localparam int RIW = $clog2(NREG);

  logic [15:0]   ir;
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] opA, opB, res;
  logic [3:0]    op;
  logic [RIW-1:0] rn, rm;
  logic [7:0]    lowByte;
  logic          rfWe;
  logic signed [PCW-1:0] offExt;

  assign op      = ir[15:12];
  assign rn      = ir[8 +: RIW];
  assign rm      = ir[4 +: RIW];
  assign lowByte = ir[7:0];
  assign offExt  = PCW'($signed(lowByte));

  assign rfWe   = strb.commit && (op == OP_LDD || op == OP_LDI ||
                                  op == OP_ADD || op == OP_SUB);
  assign dmemWe = strb.commit && (op == OP_STD || op == OP_STI);

  always_comb begin
    dmemAddr  = (op == OP_STI) ? opA : DW'(lowByte);
    dmemWdata = (op == OP_STI) ? opB : opA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir  <= '0;
      pc  <= '0;
      opA <= '0;
      opB <= '0;
      res <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (strb.irLoad) ir <= imemData;
      if (strb.opLatch) begin
        opA <= rf[rn];
        opB <= rf[rm];
      end
      if (strb.resLoad) begin
        case (op)
          OP_LDD:  res <= dmemRdata;
          OP_ADD:  res <= opA + opB;
          OP_SUB:  res <= opA - opB;
          default: res <= DW'(lowByte);
        endcase
      end
      if (rfWe) rf[rn] <= res;
      if (strb.commit) begin
        if (op == OP_BRZ && opA == '0) pc <= pc + offExt;
        else                           pc <= pc + 1'b1;
      end
    end
  end

  // R2: PC moves only on the edge after a commit phase
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.commit) |-> $stable(pc));

  // R2: instruction register changes only after a decode phase
  p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.irLoad) |-> $stable(ir));

  // R10: a write strobe is always preceded by an execute phase
  p_we_after_exec_r10: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> $past(strb.resLoad));
endmodule

// File: rtl/rfc_core.sv
module rfc_core
  import rfc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PCW  = 8,
  parameter int NREG = 16
) (
  input  logic           clk,
  input  logic           rst,
  output logic [PCW-1:0] imemAddr,
  input  logic [15:0]    imemData,
  output logic [DW-1:0]  dmemAddr,
  output logic           dmemWe,
  output logic [DW-1:0]  dmemWdata,
  input  logic [DW-1:0]  dmemRdata,
  output logic           halted
);
  ctrlStrobe_t strb;

  rfc_control u_ctrl (
    .clk(clk), .rst(rst), .fetchedOp(imemData[15:12]),
    .strb(strb), .halted(halted)
  );

  rfc_datapath #(.DW(DW), .PCW(PCW), .NREG(NREG)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .imemData(imemData),
    .dmemRdata(dmemRdata), .pc(imemAddr), .dmemAddr(dmemAddr),
    .dmemWe(dmemWe), .dmemWdata(dmemWdata)
  );

  // R8: a halted core never writes data memory
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> !dmemWe);
endmodule

// File: tb/sim_rfc_core.sv
module sim_rfc_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imemAddr;
  logic [15:0] imemData = '0;
  logic [7:0]  dmemAddr;
  logic        dmemWe;
  logic [7:0]  dmemWdata;
  logic [7:0]  dmemRdata = '0;
  logic        halted;

  logic [15:0] imem [256];
  logic [7:0]  dmem [256];

  logic [7:0] qAddr [$];
  logic [7:0] qData [$];
  string      qTag  [$];
  int         storeCyc [$];
  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  rfc_core u0 (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWe(dmemWe), .dmemWdata(dmemWdata),
    .dmemRdata(dmemRdata), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    imemData  <= imem[imemAddr];
    dmemRdata <= dmem[dmemAddr];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expectStore(input logic [7:0] a, input logic [7:0] d, input string tag);
    qAddr.push_back(a);
    qData.push_back(d);
    qTag.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && dmemWe) begin
      storeCyc.push_back(cyc);
      if (qAddr.size() == 0) begin
        check(0, "R10 unexpected store", int'(dmemAddr), -1);
      end else begin
        automatic logic [7:0] ea = qAddr.pop_front();
        automatic logic [7:0] ed = qData.pop_front();
        automatic string      et = qTag.pop_front();
        check(dmemAddr == ea, {et, " addr"}, int'(dmemAddr), int'(ea));
        check(dmemWdata == ed, {et, " data"}, int'(dmemWdata), int'(ed));
      end
    end
  end

  task automatic clearMem();
    for (int i = 0; i < 256; i++) begin
      imem[i] = 16'h0000;
      dmem[i] = 8'h00;
    end
  endtask

  task automatic runProgram(input int haltAt);
    rst = 1'b1;
    storeCyc.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(halted == 1'b0, "R1 halted in reset", int'(halted), 0);
    check(imemAddr == 8'h00, "R1 pc in reset", int'(imemAddr), 0);
    check(dmemWe == 1'b0, "R1 we in reset", int'(dmemWe), 0);
    rst = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    check(halted == 1'b1, "R8 halt reached", int'(halted), 1);
    repeat (20) @(negedge clk);
    check(halted == 1'b1 && imemAddr == 8'(haltAt), "R8 pc frozen",
          int'(imemAddr), haltAt);
    check(qAddr.size() == 0, "R10 missing stores", qAddr.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Program A: countdown sum (R9, R7 both directions, R5, R6)
    clearMem();
    imem[0]  = 16'h3000; // R0 = 0
    imem[1]  = 16'h310A; // R1 = 10
    imem[2]  = 16'h3201; // R2 = 1
    imem[3]  = 16'h3300; // R3 = 0
    imem[4]  = 16'h6104; // if R1==0 goto 8
    imem[5]  = 16'h4010; // R0 += R1
    imem[6]  = 16'h5120; // R1 -= R2
    imem[7]  = 16'h63FD; // goto 4 (R3 zero)
    imem[8]  = 16'h1020; // [0x20] = R0
    imem[9]  = 16'h1121; // [0x21] = R1
    imem[10] = 16'h1422; // [0x22] = R4 (never written)
    imem[11] = 16'hF000; // halt
    expectStore(8'h20, 8'd55, "R9 sum R0");
    expectStore(8'h21, 8'h00, "R9 count R1");
    expectStore(8'h22, 8'h00, "R1 untouched register");
    runProgram(11);

    // Program B: loads, indirect store, wrap, branch cases
    clearMem();
    dmem[8'h40] = 8'h7E;
    dmem[8'h41] = 8'h05;
    imem[0]  = 16'h1054; // [0x54] = R0, cleared by reset
    imem[1]  = 16'h0540; // R5 = [0x40]
    imem[2]  = 16'h0641; // R6 = [0x41]
    imem[3]  = 16'h4560; // R5 += R6 -> 0x83
    imem[4]  = 16'h1550; // [0x50] = R5
    imem[5]  = 16'h3790; // R7 = 0x90
    imem[6]  = 16'h2750; // [R7] = R5
    imem[7]  = 16'h3A03; // R10 = 3
    imem[8]  = 16'h5A50; // R10 -= R5 -> 0x80
    imem[9]  = 16'h1A51; // [0x51] = R10
    imem[10] = 16'h6A02; // not taken
    imem[11] = 16'h3B00; // R11 = 0
    imem[12] = 16'h6B02; // taken to 14
    imem[13] = 16'h1B52; // skipped
    imem[14] = 16'h3FFF; // R15 = 0xFF
    imem[15] = 16'h4FF0; // R15 += R15 -> 0xFE
    imem[16] = 16'h1F53; // [0x53] = R15
    imem[17] = 16'h7000; // lowest halting opcode
    expectStore(8'h54, 8'h00, "R1 register cleared by reset");
    expectStore(8'h50, 8'h83, "R3 load and R6 add");
    expectStore(8'h90, 8'h83, "R4 indirect store");
    expectStore(8'h51, 8'h80, "R6 subtract wrap and R5 immediate");
    expectStore(8'h53, 8'hFE, "R6 same-register add, R7 branch");
    runProgram(17);

    // R2: store spacing = 5 cycles per instruction (instr 0,4,6,9,16)
    if (storeCyc.size() == 5) begin
      check(storeCyc[1] - storeCyc[0] == 20, "R2 gap 0-4", storeCyc[1] - storeCyc[0], 20);
      check(storeCyc[2] - storeCyc[1] == 10, "R2 gap 4-6", storeCyc[2] - storeCyc[1], 10);
      check(storeCyc[3] - storeCyc[2] == 15, "R2 gap 6-9", storeCyc[3] - storeCyc[2], 15);
      check(storeCyc[4] - storeCyc[3] == 30, "R2 gap 9-16 (one skipped)",
            storeCyc[4] - storeCyc[3], 30);
    end else begin
      check(0, "R2 store count", storeCyc.size(), 5);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule